// File: doc/BRIEF.md
# Indirect Lookup-Table Access Port

This block gives a bus master access, through a small APB register window, to a table of address-lookup entries. Each entry is 96 bits wide, wider than one 32-bit bus word. The master never addresses the table directly. Instead it works through three staging word registers and one command register.

Writing only an index to the command register fetches that entry into the staging words. Writing the same register with the commit flag set stores the staging words into the table at the given index. Staging word 0 carries entry bits 95:64, word 1 carries bits 63:32 and word 2 carries bits 31:0, so word 0 holds the most significant part of an entry.

The window also provides an identification register with a major and a minor version, and a status register that encodes the table size. Every table entry is cleared at reset, which marks it with the free type (all zeros).

The APB side applies no back-pressure. `pready` is always high, so every access completes in its access phase. A command occupies the table for one cycle after it is accepted. During that cycle `tbl_ready` is low and the staging words may still change. A master issues its next access only in a later cycle, and the APB setup phase guarantees that on its own.

Top module: `lookup_table_port`

## Requirements
- R1: After reset, every staging word reads 0, the command register reads 0, `tbl_ready` is 1, and loading any in-range entry returns all zeros.
- R2: A read at offset 0x00 returns {16'h0, VER_MAJOR[7:0], VER_MINOR[7:0]}, with the major version in bits 15:8 and the minor version in bits 7:0.
- R3: A read at offset 0x04 returns the size code in bits 4:0 and zeros above. The code is 0 for a 64-entry table and DEPTH/1024 otherwise, so it is 0 with the default DEPTH=64.
- R4: Staging words 0, 1 and 2 sit at offsets 0x34, 0x38 and 0x3C. Each one returns the last value written to it until a load command replaces it.
- R5: A write to offset 0x20 with bit 31 clear loads the entry named by bits 9:0 into the three staging words. The load happens in the cycle after the write's access phase, and `tbl_ready` is 0 during exactly that one cycle.
- R6: A write to offset 0x20 with bit 31 set stores the three staging words into the entry named by bits 9:0. The staging words keep their values, and a later load of that index returns them.
- R7: When the index is DEPTH or above, a commit changes no entry and a load fills the staging words with zeros.
- R8: A read at offset 0x20 returns the last index written in bits 9:0, with bit 31 and all other bits zero.
- R9: A read at any offset not listed above returns 0, and a write there changes no register.
- R10: Entries are independent: committing one index leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | Byte offset in the register window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| tbl_ready | output | 1 | Low during the cycle in which a command uses the table |

## Verification
The case that is hardest to reach from the ports is an out-of-range commit. Its index aliases, in the low address bits, onto a real entry, so an index-range check that is wrong would silently corrupt entry 0. To expose that, the stimulus first stores a known pattern at index 0 and then commits different data at index 64. It then loads index 64 and expects zeros, and reloads index 0 and expects the original pattern. The one-cycle low pulse on `tbl_ready` is sampled on the two falling edges that follow the command's access phase.

// File: rtl/ltap_pkg.sv
package ltap_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 3;
  localparam int ENTRY_W = WORD_W * NWORDS;

  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_TCTL = 8'h20;
  localparam logic [7:0] OFS_W0   = 8'h34;
  localparam logic [7:0] OFS_W1   = 8'h38;
  localparam logic [7:0] OFS_W2   = 8'h3C;

  localparam int CMD_WR_BIT = 31;

  typedef enum logic [2:0] {
    RS_NONE, RS_ID, RS_STAT, RS_TCTL, RS_W0, RS_W1, RS_W2
  } regsel_e;

  typedef logic [NWORDS-1:0][WORD_W-1:0] stage_t;
endpackage

// File: rtl/ltap_decode.sv
module ltap_decode
  import ltap_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output regsel_e           sel
);
  localparam int LOW_W = (ADDR_W < 8) ? ADDR_W : 8;

  logic [7:0] low;
  logic       high_zero;

  always_comb begin
    low = '0;
    low[LOW_W-1:0] = addr[LOW_W-1:0];
  end

  generate
    if (ADDR_W > 8) begin : g_high
      assign high_zero = (addr[ADDR_W-1:8] == '0);
    end else begin : g_nohigh
      assign high_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    sel = RS_NONE;
    if (high_zero) begin
      case (low)
        OFS_ID:   sel = RS_ID;
        OFS_STAT: sel = RS_STAT;
        OFS_TCTL: sel = RS_TCTL;
        OFS_W0:   sel = RS_W0;
        OFS_W1:   sel = RS_W1;
        OFS_W2:   sel = RS_W2;
        default:  sel = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ltap_cmd.sv
module ltap_cmd
  import ltap_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int IDXF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tctl_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic              busy,
  output logic [IDXF_W-1:0] cmd_idx,
  output logic              in_range,
  output logic              ld_pulse,
  output logic              st_pulse
);
  logic cmd_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cmd_write <= 1'b0;
      cmd_idx   <= '0;
    end else if (tctl_wr) begin
      busy      <= 1'b1;
      cmd_write <= wdata[CMD_WR_BIT];
      cmd_idx   <= wdata[IDXF_W-1:0];
    end else begin
      busy      <= 1'b0;
    end
  end

  assign in_range = (32'(cmd_idx) < DEPTH);
  assign ld_pulse = busy & ~cmd_write;
  assign st_pulse = busy & cmd_write;

  // R5: a command holds the table for exactly one cycle
  a_r5_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tctl_wr |=> !busy);
  a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tctl_wr |=> busy);
endmodule

// File: rtl/ltap_store.sv
module ltap_store
  import ltap_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW_M = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW_M-1:0]    addr,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] rdata
);
  logic [DEPTH-1:0][ENTRY_W-1:0] ent;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent[e] <= '0;
        else if (we && (32'(addr) == e)) ent[e] <= wdata;
      end
    end
  endgenerate

  assign rdata = (32'(addr) < DEPTH) ? ent[addr] : '0;

  // R10: the addressed entry takes the written value
  a_r10_store_hits: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == $past(wdata) || addr != $past(addr));
endmodule

// File: rtl/ltap_stage.sv
module ltap_stage
  import ltap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NWORDS-1:0]  wr_en,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               load,
  input  logic [ENTRY_W-1:0] load_val,
  output stage_t             words,
  output logic [ENTRY_W-1:0] entry
);
  generate
    for (genvar k = 0; k < NWORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        words[k] <= '0;
        else if (load)     words[k] <= load_val[(NWORDS-1-k)*WORD_W +: WORD_W];
        else if (wr_en[k]) words[k] <= wdata;
      end
      assign entry[(NWORDS-1-k)*WORD_W +: WORD_W] = words[k];
    end
  endgenerate

  // R4: staging words only change on a bus write or a load
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load && wr_en == '0 |=> $stable(words));
endmodule

// File: rtl/lookup_table_port.sv
module lookup_table_port
  import ltap_pkg::*;
#(
  parameter int         DEPTH     = 64,
  parameter int         IDXF_W    = 10,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              tbl_ready
);
  localparam int AW_M = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [4:0] SIZE_CODE = (DEPTH <= 64) ? 5'd0 : 5'(DEPTH / 1024);

  regsel_e             sel;
  logic                wr_acc;
  logic                tctl_wr;
  logic [NWORDS-1:0]   w_en;
  logic                busy, in_range, ld_pulse, st_pulse;
  logic [IDXF_W-1:0]   cmd_idx;
  logic [ENTRY_W-1:0]  mem_rd, load_val, entry;
  stage_t              words;

  ltap_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(paddr), .sel(sel));

  assign wr_acc  = psel & penable & pwrite;
  assign tctl_wr = wr_acc && (sel == RS_TCTL);
  assign w_en[0] = wr_acc && (sel == RS_W0);
  assign w_en[1] = wr_acc && (sel == RS_W1);
  assign w_en[2] = wr_acc && (sel == RS_W2);

  ltap_cmd #(.DEPTH(DEPTH), .IDXF_W(IDXF_W)) u_cmd (
    .clk(pclk), .rst_n(presetn), .tctl_wr(tctl_wr), .wdata(pwdata),
    .busy(busy), .cmd_idx(cmd_idx), .in_range(in_range),
    .ld_pulse(ld_pulse), .st_pulse(st_pulse));

  ltap_store #(.DEPTH(DEPTH)) u_store (
    .clk(pclk), .rst_n(presetn), .we(st_pulse & in_range),
    .addr(cmd_idx[AW_M-1:0]), .wdata(entry), .rdata(mem_rd));

  assign load_val = in_range ? mem_rd : '0;

  ltap_stage u_stage (
    .clk(pclk), .rst_n(presetn), .wr_en(w_en), .wdata(pwdata),
    .load(ld_pulse), .load_val(load_val), .words(words), .entry(entry));

  always_comb begin
    prdata = '0;
    case (sel)
      RS_ID:   prdata = {16'h0, VER_MAJOR, VER_MINOR};
      RS_STAT: prdata = {27'h0, SIZE_CODE};
      RS_TCTL: prdata = 32'(cmd_idx);
      RS_W0:   prdata = words[0];
      RS_W1:   prdata = words[1];
      RS_W2:   prdata = words[2];
      default: prdata = '0;
    endcase
  end

  assign pready    = 1'b1;
  assign tbl_ready = ~busy;

  // R7: an out-of-range load leaves zeros in the staging words
  a_r7_oor_zero: assert property (@(posedge pclk) disable iff (!presetn)
    ld_pulse && !in_range |=> words == '0);
  // R6: a commit leaves the staging words untouched
  a_r6_commit_keeps: assert property (@(posedge pclk) disable iff (!presetn)
    st_pulse |=> $stable(words));
endmodule

// File: tb/sim_lookup_table_port.sv
module sim_lookup_table_port;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam logic [105:0] VEC [NV] = '{
    {10'd0,  96'h0123_4567_89AB_CDEF_0011_2233},
    {10'd63, 96'hFFFF_0000_A5A5_5A5A_DEAD_BEEF},
    {10'd1,  96'h0000_0001_0000_0002_0000_0003},
    {10'd32, 96'h8000_0000_7FFF_FFFF_1357_9BDF},
    {10'd17, 96'hCAFE_F00D_0BAD_C0DE_2468_ACE0},
    {10'd5,  96'h3000_0000_0000_0000_0000_0001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, tbl_ready;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lookup_table_port u0 (.pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .tbl_ready(tbl_ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    while (!pready) @(negedge clk);
    rd = prdata;
    @(posedge clk);
    #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] x;
    bus(1'b1, a, d, x);
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] x;
    bus(1'b0, a, 32'h0, x);
    check(req, x, exp);
  endtask

  task automatic put_words(input logic [95:0] e);
    wr(8'h34, e[95:64]); wr(8'h38, e[63:32]); wr(8'h3C, e[31:0]);
  endtask

  task automatic chk_words(input string req, input logic [95:0] e);
    rdchk(req, 8'h34, e[95:64]); rdchk(req, 8'h38, e[63:32]); rdchk(req, 8'h3C, e[31:0]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk);
    check("R1 tbl_ready", 32'(tbl_ready), 32'd1);
    chk_words("R1 words", 96'h0);
    rdchk("R1 tctl", 8'h20, 32'h0);
    put_words(96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
    wr(8'h20, 32'd10);
    chk_words("R1 entry cleared", 96'h0);
    // R2 / R3
    rdchk("R2 id", 8'h00, 32'h0000_0104);
    rdchk("R3 status", 8'h04, 32'h0);

    // R4/R6 commit pass over the vector table
    for (int i = 0; i < NV; i++) begin
      put_words(VEC[i][95:0]);
      chk_words("R4 word rw", VEC[i][95:0]);
      wr(8'h20, 32'h8000_0000 | 32'(VEC[i][105:96]));
      chk_words("R6 commit keeps words", VEC[i][95:0]);
    end
    // R5/R10 load pass: clear staging first, then load each entry
    for (int i = 0; i < NV; i++) begin
      put_words(96'h0);
      wr(8'h20, 32'(VEC[i][105:96]));
      chk_words("R5 R10 load", VEC[i][95:0]);
    end

    // R5 ready timing
    wr(8'h20, 32'd1);
    @(negedge clk);
    check("R5 tbl_ready low", 32'(tbl_ready), 32'd0);
    @(negedge clk);
    check("R5 tbl_ready back", 32'(tbl_ready), 32'd1);

    // R7 out of range: commit at 64 must not alias onto entry 0
    put_words(96'h1111_2222_3333_4444_5555_6666);
    wr(8'h20, 32'h8000_0040);
    wr(8'h20, 32'h0000_0040);
    chk_words("R7 oor load zero", 96'h0);
    wr(8'h20, 32'd0);
    chk_words("R7 entry0 intact", VEC[0][95:0]);
    wr(8'h20, 32'h0000_03FF);
    chk_words("R7 top index zero", 96'h0);

    // R8 command readback
    wr(8'h20, 32'h8000_0011);
    rdchk("R8 tctl readback", 8'h20, 32'h0000_0011);

    // R9 unmapped offsets
    wr(8'h20, 32'd63);
    wr(8'h10, 32'hABCD_EF01);
    rdchk("R9 unmapped read", 8'h10, 32'h0);
    rdchk("R9 unmapped read2", 8'h40, 32'h0);
    chk_words("R9 no side effect", VEC[1][95:0]);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule